// File: doc/BRIEF.md
# Retriggerable Resettable Pulse Stretcher

This block is a clocked one-shot. It watches two trigger pins. One pin responds to a high-to-low edge. The other responds to a low-to-high edge. Each edge counts only while the opposite pin sits at its enabling level. A counted edge drives the true output high for a programmable number of clock cycles. A complementary output always holds the inverse value.

In the default mode, a counted edge that arrives during a pulse restarts the count from the full length, so the pulse stretches with no gap. With the retrigger-enable input low, edges are ignored until the pulse has finished. An active-low clear overrides everything: it ends a running pulse and holds the output low while it stays asserted. Releasing the clear never starts a pulse by itself. A counted edge that arrives together with the release still starts one.

All three asynchronous pins pass through a two-stage synchronizer before edge detection. Edge detection stays disabled until the synchronizer holds real samples after reset. Because of this, levels that are present when reset ends are never taken as edges. The mode input and the length input are treated as synchronous to the clock.

Top module: `oneshot_pulse_gen`

## Requirements
- R1: A high-to-low change on `trig_fall_n` starts a pulse only while `trig_rise` is high. With `trig_rise` low, that change starts no pulse.
- R2: A low-to-high change on `trig_rise` starts a pulse only while `trig_fall_n` is low. With `trig_fall_n` high, that change starts no pulse.
- R3: A pin change driven just after a rising clock edge shows on `pulse_q` after the third rising edge that follows. The pulse then stays high for exactly `pulse_len` cycles, using the value sampled when the trigger is taken.
- R4: With `retrig_en` = 1, a counted edge during a pulse reloads the full length. The output stays high without a gap until `pulse_len` cycles after the retrigger takes effect.
- R5: `clear_n` held low forces `pulse_q` low no later than the third rising edge after the pin falls. Triggers arriving while it is low produce no output.
- R6: A low-to-high change on `clear_n` starts no pulse, even when the trigger pins sit at their enabling levels.
- R7: When the synchronized clear release and a counted edge land in the same cycle, a full-length pulse starts.
- R8: With `retrig_en` = 0, counted edges are ignored while a pulse is running. The pulse ends `pulse_len` cycles after it started.
- R9: `pulse_qn` is always the inverse of `pulse_q`.
- R10: A counted edge taken with `pulse_len` = 0 starts no pulse.
- R11: With `retrig_en` = 0, an edge taken in the first cycle after a pulse ends starts a new pulse. This leaves exactly one low cycle between the two pulses.
- R12: During reset `pulse_q` is low. Trigger levels that are already present when reset ends start no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_fall_n | input | 1 | Trigger on a high-to-low edge, asynchronous |
| trig_rise | input | 1 | Trigger on a low-to-high edge, asynchronous |
| clear_n | input | 1 | Overriding clear, active low, asynchronous |
| retrig_en | input | 1 | 1 = retriggerable, 0 = edges ignored during a pulse |
| pulse_len | input | LEN_W | Pulse length in clock cycles |
| pulse_q | output | 1 | True pulse output |
| pulse_qn | output | 1 | Complementary pulse output |

## Verification
A wrong count value shows at the ports as a pulse of the wrong length. It appears at the first cycle where the expected and observed edges of `pulse_q` disagree, which is at most `pulse_len` cycles after the trigger. A wrong edge-detector history or warm-up state shows as a spurious or missing pulse within three cycles of the pin change. The bench stimulates each trigger pin under both levels of the other pin, and records every output cycle of each window. It then compares the first high cycle, the last high cycle and the number of high cycles against the values the requirements give.

// File: rtl/osp_pkg.sv
`timescale 1ns/1ps
package osp_pkg;

    // Raw or synchronized view of the three asynchronous pins.
    typedef struct packed {
        logic fall_n;
        logic rise;
        logic clr_n;
    } osp_pins_t;

    localparam int PIN_COUNT = $bits(osp_pins_t);

    // Levels that never produce an edge: falling trigger high, rising low, clear off.
    localparam osp_pins_t PINS_IDLE = '{fall_n: 1'b1, rise: 1'b0, clr_n: 1'b1};

    // Decoded events handed to the timer.
    typedef struct packed {
        logic fall_hit;
        logic rise_hit;
        logic clr_ok;
    } osp_event_t;

    function automatic logic went_low(input logic prv, input logic cur);
        return prv & ~cur;
    endfunction

    function automatic logic went_high(input logic prv, input logic cur);
        return ~prv & cur;
    endfunction

endpackage

// File: rtl/osp_sync.sv
`timescale 1ns/1ps
module osp_sync #(
    parameter int               WIDTH   = 3,
    parameter int               DEPTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    // One independent shift chain per bit; the chain length sets the latency.
    generate
        for (genvar g = 0; g < WIDTH; g++) begin : g_bit
            logic [DEPTH-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain <= {DEPTH{RST_VAL[g]}};
                end else begin
                    chain <= {chain[DEPTH-2:0], d[g]};
                end
            end
            assign q[g] = chain[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/osp_edge.sv
`timescale 1ns/1ps
module osp_edge
    import osp_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  osp_pins_t  cur,
    output osp_event_t ev
);

    // Edges are trusted only once both the synchronizer and the history
    // register hold post-reset samples.
    localparam int WARM = DEPTH + 1;
    localparam int WW   = $clog2(WARM + 1);

    logic [WW-1:0] warm;
    logic          armed;
    osp_pins_t     prev;

    assign armed = (warm == WW'(WARM));

    always_ff @(posedge clk) begin
        if (rst) begin
            warm <= '0;
            prev <= PINS_IDLE;
        end else begin
            prev <= cur;
            if (!armed) begin
                warm <= warm + 1'b1;
            end
        end
    end

    // Each edge is qualified by the level on the opposite trigger pin.
    always_comb begin
        ev.fall_hit = armed & went_low(prev.fall_n, cur.fall_n) & cur.rise;
        ev.rise_hit = armed & went_high(prev.rise, cur.rise) & ~cur.fall_n;
        ev.clr_ok   = cur.clr_n;
    end

endmodule

// File: rtl/osp_timer.sv
`timescale 1ns/1ps
module osp_timer #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             clr_ok,
    input  logic             retrig_en,
    input  logic [LEN_W-1:0] len,
    output logic [LEN_W-1:0] cnt,
    output logic             active
);

    logic may_load;

    assign active   = (cnt != '0);
    assign may_load = retrig_en | ~active;

    // Clear dominates, then a permitted trigger reloads, otherwise count down.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!clr_ok) begin
            cnt <= '0;
        end else if (start && may_load) begin
            cnt <= len;
        end else if (active) begin
            cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/oneshot_pulse_gen.sv
`timescale 1ns/1ps
module oneshot_pulse_gen
    import osp_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_fall_n,
    input  logic             trig_rise,
    input  logic             clear_n,
    input  logic             retrig_en,
    input  logic [LEN_W-1:0] pulse_len,
    output logic             pulse_q,
    output logic             pulse_qn
);

    osp_pins_t        raw_pins;
    osp_pins_t        sync_pins;
    osp_event_t       ev;
    logic             start_hit;
    logic             clr_ok;
    logic [LEN_W-1:0] cnt;
    logic             active;

    assign raw_pins = '{fall_n: trig_fall_n, rise: trig_rise, clr_n: clear_n};

    osp_sync #(
        .WIDTH   (PIN_COUNT),
        .DEPTH   (SYNC_DEPTH),
        .RST_VAL (PINS_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_pins),
        .q   (sync_pins)
    );

    osp_edge #(
        .DEPTH (SYNC_DEPTH)
    ) u_edge (
        .clk (clk),
        .rst (rst),
        .cur (sync_pins),
        .ev  (ev)
    );

    assign start_hit = ev.fall_hit | ev.rise_hit;
    assign clr_ok    = ev.clr_ok;

    osp_timer #(
        .LEN_W (LEN_W)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .start     (start_hit),
        .clr_ok    (clr_ok),
        .retrig_en (retrig_en),
        .len       (pulse_len),
        .cnt       (cnt),
        .active    (active)
    );

    assign pulse_q  = active;
    assign pulse_qn = ~active;

endmodule

// File: rtl/osp_checker.sv
`timescale 1ns/1ps
module osp_checker #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             retrig_en,
    input logic [LEN_W-1:0] pulse_len,
    input logic             clear_n,
    input logic             pulse_q,
    input logic             pulse_qn,
    input logic             hit,
    input logic             clr_ok,
    input logic [LEN_W-1:0] cnt
);

    // Cycles seen since reset, saturating; guards the two-deep history below.
    logic [1:0] seen;
    always_ff @(posedge clk) begin
        if (rst) begin
            seen <= '0;
        end else if (seen != 2'd3) begin
            seen <= seen + 1'b1;
        end
    end

    p_complement_r9: assert property (@(posedge clk) disable iff (rst)
        pulse_qn == ~pulse_q);

    p_clear_forces_low_r5: assert property (@(posedge clk) disable iff (rst)
        (seen == 2'd3 && !clear_n && !$past(clear_n) && !$past(clear_n, 2)) |=> !pulse_q);

    p_start_needs_hit_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_q) |-> $past(hit));

    p_full_reload_r4: assert property (@(posedge clk) disable iff (rst)
        (hit && clr_ok && (retrig_en || cnt == '0)) |=> cnt == $past(pulse_len));

    p_no_retrig_hold_r8: assert property (@(posedge clk) disable iff (rst)
        $past(!retrig_en && clr_ok && cnt > LEN_W'(1)) |-> cnt == $past(cnt) - LEN_W'(1));

    p_zero_len_r10: assert property (@(posedge clk) disable iff (rst)
        (hit && clr_ok && cnt == '0 && pulse_len == '0) |=> !pulse_q);

endmodule

bind oneshot_pulse_gen osp_checker #(.LEN_W(LEN_W)) u_osp_chk (
    .clk       (clk),
    .rst       (rst),
    .retrig_en (retrig_en),
    .pulse_len (pulse_len),
    .clear_n   (clear_n),
    .pulse_q   (pulse_q),
    .pulse_qn  (pulse_qn),
    .hit       (start_hit),
    .clr_ok    (clr_ok),
    .cnt       (cnt)
);

// File: tb/oneshot_pulse_gen_bench.sv
`timescale 1ns/1ps
module oneshot_pulse_gen_bench;

    localparam int LEN_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             trig_fall_n = 1'b0;
    logic             trig_rise = 1'b1;
    logic             clear_n = 1'b1;
    logic             retrig_en = 1'b1;
    logic [LEN_W-1:0] pulse_len = 16'd7;
    logic             pulse_q;
    logic             pulse_qn;

    int  n_tests = 0;
    int  n_fail  = 0;
    int  qn_bad  = 0;
    bit  done    = 1'b0;
    bit  hist [0:63];

    always #2.5 clk = ~clk;

    oneshot_pulse_gen #(.LEN_W(LEN_W), .SYNC_DEPTH(2)) u_oneshot_pulse_gen (
        .clk         (clk),
        .rst         (rst),
        .trig_fall_n (trig_fall_n),
        .trig_rise   (trig_rise),
        .clear_n     (clear_n),
        .retrig_en   (retrig_en),
        .pulse_len   (pulse_len),
        .pulse_q     (pulse_q),
        .pulse_qn    (pulse_qn)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Advance one clock and sample 1 ns after the edge; R9 is watched every cycle.
    task automatic rec(input int idx);
        @(posedge clk);
        #1;
        hist[idx] = pulse_q;
        if (pulse_qn !== ~pulse_q) qn_bad++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) rec(0);
    endtask

    task automatic capture(input int n);
        for (int i = 1; i <= n; i++) rec(i);
    endtask

    task automatic stats(input int n, output int first, output int last, output int total);
        first = -1; last = -1; total = 0;
        for (int i = 1; i <= n; i++) begin
            if (hist[i]) begin
                if (first < 0) first = i;
                last = i;
                total++;
            end
        end
    endtask

    task automatic settle();
        trig_fall_n = 1'b1;
        trig_rise   = 1'b0;
        clear_n     = 1'b1;
        retrig_en   = 1'b1;
        idle(30);
    endtask

    task automatic t_reset();
        int f, l, c;
        idle(4);
        check(pulse_q == 1'b0, "R12", "pulse_q in reset", pulse_q, 0);
        check(pulse_qn == 1'b1, "R9", "pulse_qn in reset", pulse_qn, 1);
        rst = 1'b0;
        capture(20);
        stats(20, f, l, c);
        check(c == 0, "R12", "high cycles after reset with enabling levels", c, 0);
        settle();
    endtask

    task automatic t_fall_qualified();
        int f, l, c;
        pulse_len = 16'd6;
        trig_rise = 1'b1;
        idle(6);
        trig_fall_n = 1'b0;
        capture(20);
        stats(20, f, l, c);
        check(f == 3, "R3", "first high step", f, 3);
        check(c == 6, "R1", "qualified falling edge pulse length", c, 6);
        settle();
    endtask

    task automatic t_fall_unqualified();
        int f, l, c;
        pulse_len = 16'd6;
        trig_fall_n = 1'b0;
        capture(20);
        stats(20, f, l, c);
        check(c == 0, "R1", "falling edge with rise pin low", c, 0);
        settle();
    endtask

    task automatic t_rise_qualified();
        int f, l, c;
        pulse_len = 16'd5;
        trig_fall_n = 1'b0;
        idle(6);
        trig_rise = 1'b1;
        capture(20);
        stats(20, f, l, c);
        check(f == 3, "R3", "first high step on rising trigger", f, 3);
        check(c == 5, "R2", "qualified rising edge pulse length", c, 5);
        settle();
    endtask

    task automatic t_rise_unqualified();
        int f, l, c;
        pulse_len = 16'd5;
        trig_rise = 1'b1;
        capture(20);
        stats(20, f, l, c);
        check(c == 0, "R2", "rising edge with fall pin high", c, 0);
        settle();
    endtask

    task automatic t_retrigger(input bit mode);
        int f, l, c;
        pulse_len = 16'd8;
        retrig_en = mode;
        trig_fall_n = 1'b0;
        idle(6);
        trig_rise = 1'b1;
        for (int i = 1; i <= 25; i++) begin
            rec(i);
            if (i == 2) trig_rise = 1'b0;
            if (i == 5) trig_rise = 1'b1;
        end
        stats(25, f, l, c);
        if (mode) begin
            check(l == 15, "R4", "last high step after retrigger", l, 15);
            check(c == l - f + 1 && c == 13, "R4", "continuous high cycles", c, 13);
        end else begin
            check(c == 8, "R8", "edge ignored during pulse", c, 8);
            check(l == 10, "R8", "last high step without retrigger", l, 10);
        end
        settle();
    endtask

    task automatic t_clear();
        int f, l, c, after;
        pulse_len = 16'd20;
        trig_fall_n = 1'b0;
        idle(6);
        trig_rise = 1'b1;
        for (int i = 1; i <= 35; i++) begin
            rec(i);
            if (i == 5)  clear_n = 1'b0;
            if (i == 10) trig_rise = 1'b0;
            if (i == 12) trig_rise = 1'b1;
            if (i == 20) clear_n = 1'b1;
        end
        stats(35, f, l, c);
        check(c == 5 && l == 7, "R5", "high cycles before clear takes hold", c, 5);
        after = 0;
        for (int i = 21; i <= 35; i++) if (hist[i]) after++;
        check(after == 0, "R6", "high cycles after clear release", after, 0);
        settle();
    endtask

    task automatic t_clear_with_trigger();
        int f, l, c;
        pulse_len = 16'd6;
        clear_n = 1'b0;
        trig_fall_n = 1'b0;
        trig_rise = 1'b0;
        idle(6);
        clear_n = 1'b1;
        trig_rise = 1'b1;
        capture(20);
        stats(20, f, l, c);
        check(f == 3 && c == 6, "R7", "pulse on coincident release and edge", c, 6);
        settle();
    endtask

    task automatic t_zero_len();
        int f, l, c;
        pulse_len = 16'd0;
        trig_fall_n = 1'b0;
        idle(6);
        trig_rise = 1'b1;
        capture(20);
        stats(20, f, l, c);
        check(c == 0, "R10", "high cycles for zero length", c, 0);
        settle();
    endtask

    task automatic t_back_to_back();
        int f, l, c;
        pulse_len = 16'd4;
        retrig_en = 1'b0;
        trig_fall_n = 1'b0;
        idle(6);
        trig_rise = 1'b1;
        for (int i = 1; i <= 20; i++) begin
            rec(i);
            if (i == 1) trig_rise = 1'b0;
            if (i == 5) trig_rise = 1'b1;
        end
        stats(20, f, l, c);
        check(hist[7] == 1'b0, "R11", "single gap cycle level", hist[7], 0);
        check(hist[8] == 1'b1 && c == 8, "R11", "second pulse cycles", c, 8);
        settle();
    endtask

    initial begin
        t_reset();
        t_fall_qualified();
        t_fall_unqualified();
        t_rise_qualified();
        t_rise_unqualified();
        t_retrigger(1'b1);
        t_retrigger(1'b0);
        t_clear();
        t_clear_with_trigger();
        t_zero_len();
        t_back_to_back();
        check(qn_bad == 0, "R9", "cycles with pulse_qn not inverse", qn_bad, 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule